// File: doc/BRIEF.md
# Hardware Thread Interface Controller

This block sits between one user hardware thread and a shared system bus. It keeps track of whether the thread is idle, running or waiting, and it performs memory accesses and synchronization requests on the thread's behalf. The user logic presents an operation code for one cycle. The controller turns it into a single bus read or write aimed at a memory location or at a spin lock, mutex or counting semaphore unit. It then reports a per-operation return code in its status register. A CPU-side command port starts the thread out of idle and wakes it when a blocking request was queued by the lock unit.

The two kinds of lock are handled differently. A spin lock acquire puts the thread into waiting for exactly one bus read. As soon as the reply arrives, the thread runs again and reads the reply word to decide whether it owns the lock. A blocking acquire (mutex lock or semaphore wait) also puts the thread into waiting and issues one read. If the reply says the thread was queued, the controller stays in waiting until a wake command arrives. Lock requests put the lock number and the controller's own thread number into the bus address, so each request is a single transfer.

Top module: `hw_thread_ctrl`

## Requirements
- R1: After reset the thread state is idle (0), no bus request is raised, the status code is 0 and the done strobe is low.
- R2: A run command (cmd_code 2'b01) moves the thread from idle to running on the next clock edge. A run command in any other state has no effect, and a wake command (2'b10) in idle has no effect.
- R3: An operation is accepted only while the thread is running and no earlier request is pending. Otherwise it is ignored: no bus request and no change of state or status code.
- R4: READ (op 1) and WRITE (op 2) each make one bus transfer, at op_addr, with write data op_wdata for WRITE, and the thread stays running. On the reply the status code becomes 1 or 2 respectively, and for a read the reply word appears on rdata.
- R5: The release operations are SEMPOST (op 3), MTXUNLK (op 6) and SPUNLK (op 8). Each makes one bus write with write data equal to the thread number, and the thread stays running. The address is the selected unit's base bits above bit 17, then bits [16:15]=2'b01, then the lock number (op_addr[5:0]) in [14:9], then the thread number in [8:0]. The status code on the reply equals the op code.
- R6: SPLOCK (op 7) enters waiting on the accepting edge and issues one bus read, with bits [16:15]=2'b00 and the same lock and thread fields. On the reply the thread returns to running with status code 7 and the reply word on rdata, whatever its value.
- R7: SEMWAIT (op 4) and MTXLOCK (op 5) enter waiting and issue one bus read. A non-zero reply returns the thread to running with status code equal to the op code. A zero reply leaves it waiting, with the blocked flag set and no further bus request, until a wake command returns it to running and posts the status code.
- R8: A wake command has no effect while the thread is running, or while a lock request is still outstanding on the bus.
- R9: EXIT (op 9) returns the thread to idle with status code 9 and makes no bus transfer.
- R10: Op codes 0 and 10 to 15 make no bus transfer, leave the state unchanged, and post status code 15.
- R11: The done strobe is high for exactly one cycle each time a status code is posted, and a bus operation's code is cleared to 0 when it is accepted.
- R12: dbg_status holds the state in [7:6] (0 idle, 1 running, 2 waiting), the pending flag in [5], the blocked flag in [4] and the status code in [3:0].
- R13: Once raised, bus_req stays high with address, direction and write data unchanged until the cycle in which bus_ack is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | User operation strobe |
| op_code | input | 4 | User operation code |
| op_addr | input | ADDR_W | Memory address, or lock number in the low bits |
| op_wdata | input | DATA_W | Write data for WRITE |
| cmd_valid | input | 1 | CPU command strobe |
| cmd_code | input | 2 | 2'b01 run, 2'b10 wake |
| status_code | output | 4 | Return code of the last operation |
| done | output | 1 | One-cycle strobe when a return code is posted |
| rdata | output | DATA_W | Reply word of the last bus operation |
| thread_state | output | 2 | 0 idle, 1 running, 2 waiting |
| dbg_status | output | 8 | Packed state, pending, blocked and status code |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | Bus direction, 1 for write |
| bus_addr | output | ADDR_W | Bus address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | Bus reply strobe |
| bus_rdata | input | DATA_W | Bus reply word |

## Verification
The bench sends wake commands at the moments they must be ignored: while a spin request is still on the bus, and while the thread is running. A controller that honoured them would return to running early or post a code with no reply. It stalls the bus for several cycles with a second operation pending. A design that re-launched or dropped the request would show a changed address or a second transfer. A zero reply to a blocking wait must keep the thread parked with the bus quiet, while a nonzero spin reply must still release the thread. The bench also checks the packed lock address fields bit for bit, because a swapped release bit or thread field would send the request to the wrong lock.

// File: rtl/hwt_pkg.sv
// Shared codes and types for the hardware thread interface controller.
// Assumes 4-bit operation and return codes and a 2-bit command code.
package hwt_pkg;

    localparam logic [3:0] OP_NOP     = 4'd0;
    localparam logic [3:0] OP_READ    = 4'd1;
    localparam logic [3:0] OP_WRITE   = 4'd2;
    localparam logic [3:0] OP_SEMPOST = 4'd3;
    localparam logic [3:0] OP_SEMWAIT = 4'd4;
    localparam logic [3:0] OP_MTXLOCK = 4'd5;
    localparam logic [3:0] OP_MTXUNLK = 4'd6;
    localparam logic [3:0] OP_SPLOCK  = 4'd7;
    localparam logic [3:0] OP_SPUNLK  = 4'd8;
    localparam logic [3:0] OP_EXIT    = 4'd9;

    localparam logic [3:0] RC_NONE     = 4'd0;
    localparam logic [3:0] RC_RD_DONE  = 4'd1;
    localparam logic [3:0] RC_WR_DONE  = 4'd2;
    localparam logic [3:0] RC_POSTED   = 4'd3;
    localparam logic [3:0] RC_SEM_HELD = 4'd4;
    localparam logic [3:0] RC_MTX_HELD = 4'd5;
    localparam logic [3:0] RC_MTX_FREE = 4'd6;
    localparam logic [3:0] RC_SPIN_ANS = 4'd7;
    localparam logic [3:0] RC_SPIN_REL = 4'd8;
    localparam logic [3:0] RC_EXITED   = 4'd9;
    localparam logic [3:0] RC_BAD_OP   = 4'd15;

    localparam logic [1:0] CMD_RUN  = 2'b01;
    localparam logic [1:0] CMD_WAKE = 2'b10;

    typedef enum logic [1:0] {
        THR_IDLE = 2'd0,
        THR_RUN  = 2'd1,
        THR_WAIT = 2'd2
    } thr_state_e;

    typedef enum logic [1:0] {
        SYNC_NONE  = 2'd0,
        SYNC_SPIN  = 2'd1,
        SYNC_BLOCK = 2'd2
    } sync_e;

    typedef enum logic [1:0] {
        UNIT_MEM  = 2'd0,
        UNIT_SPIN = 2'd1,
        UNIT_MTX  = 2'd2,
        UNIT_SEM  = 2'd3
    } unit_e;

    typedef struct packed {
        logic       legal;
        logic       uses_bus;
        logic       bus_write;
        unit_e      unit;
        sync_e      sync;
        logic       leave;
        logic [3:0] rc;
    } op_info_t;

endpackage

// File: rtl/hwt_op_decode.sv
// Operation decoder: maps a user op code to its bus use, target unit,
// synchronization kind and return code. Purely combinational.
module hwt_op_decode
    import hwt_pkg::*;
(
    input  logic [3:0] op_code,
    output op_info_t   info
);

    // Table lookup of the operation's properties.
    always_comb begin
        info = '{legal: 1'b1, uses_bus: 1'b1, bus_write: 1'b0, unit: UNIT_MEM,
                 sync: SYNC_NONE, leave: 1'b0, rc: RC_BAD_OP};
        unique case (op_code)
            OP_READ:    info.rc = RC_RD_DONE;
            OP_WRITE:   begin info.bus_write = 1'b1; info.rc = RC_WR_DONE; end
            OP_SEMPOST: begin info.bus_write = 1'b1; info.unit = UNIT_SEM;  info.rc = RC_POSTED;   end
            OP_SEMWAIT: begin info.unit = UNIT_SEM;  info.sync = SYNC_BLOCK; info.rc = RC_SEM_HELD; end
            OP_MTXLOCK: begin info.unit = UNIT_MTX;  info.sync = SYNC_BLOCK; info.rc = RC_MTX_HELD; end
            OP_MTXUNLK: begin info.bus_write = 1'b1; info.unit = UNIT_MTX;  info.rc = RC_MTX_FREE; end
            OP_SPLOCK:  begin info.unit = UNIT_SPIN; info.sync = SYNC_SPIN;  info.rc = RC_SPIN_ANS; end
            OP_SPUNLK:  begin info.bus_write = 1'b1; info.unit = UNIT_SPIN; info.rc = RC_SPIN_REL; end
            OP_EXIT:    begin info.uses_bus = 1'b0; info.leave = 1'b1; info.rc = RC_EXITED; end
            default:    begin info.legal = 1'b0; info.uses_bus = 1'b0; end
        endcase
    end

endmodule

// File: rtl/hwt_addr_gen.sv
// Bus address and write data builder. For memory operations the user
// address and data pass through. For lock operations the address packs
// unit base bits, a release flag, the lock number and this thread's number,
// and the write data is the thread number. Assumes ADDR_W > LOW_W and
// DATA_W >= TID_W.
module hwt_addr_gen
    import hwt_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                LOCK_W    = 6,
    parameter int                TID_W     = 9,
    parameter logic [TID_W-1:0]  THREAD_ID = '0,
    parameter logic [ADDR_W-1:0] SPIN_BASE = '0,
    parameter logic [ADDR_W-1:0] MTX_BASE  = '0,
    parameter logic [ADDR_W-1:0] SEM_BASE  = '0
) (
    input  op_info_t          info,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int LOW_W = 2 + LOCK_W + TID_W;

    logic [ADDR_W-1:0] base;

    // Choose the base region of the addressed lock unit.
    always_comb begin
        unique case (info.unit)
            UNIT_SPIN: base = SPIN_BASE;
            UNIT_MTX:  base = MTX_BASE;
            UNIT_SEM:  base = SEM_BASE;
            default:   base = '0;
        endcase
    end

    // Pack the lock request address or pass the memory address through.
    always_comb begin
        if (info.unit == UNIT_MEM) begin
            addr  = op_addr;
            wdata = op_wdata;
        end else begin
            addr  = {base[ADDR_W-1:LOW_W], 1'b0, info.bus_write,
                     op_addr[LOCK_W-1:0], THREAD_ID};
            wdata = DATA_W'(THREAD_ID);
        end
    end

endmodule

// File: rtl/hwt_bus_seq.sv
// Bus request sequencer: holds one request with its address, direction
// and data steady from launch until the bus acknowledges it. Assumes the
// launch strobe never fires while a request is outstanding.
module hwt_bus_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we,
    input  logic [DATA_W-1:0] l_wdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    output logic              reply
);

    assign reply = bus_req & bus_ack;

    // Load a request on launch and drop it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req   <= 1'b0;
            bus_we    <= 1'b0;
            bus_addr  <= '0;
            bus_wdata <= '0;
        end else if (launch) begin
            bus_req   <= 1'b1;
            bus_we    <= l_we;
            bus_addr  <= l_addr;
            bus_wdata <= l_wdata;
        end else if (reply) begin
            bus_req   <= 1'b0;
        end
    end

endmodule

// File: rtl/hwt_state_ctrl.sv
// Thread state machine: accepts user operations, tracks idle, running
// and waiting, separates spin and blocking acquires, and posts return
// codes. Assumes the reply strobe only occurs while a request is pending.
module hwt_state_ctrl
    import hwt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  op_info_t          info,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    input  logic              reply,
    input  logic [DATA_W-1:0] reply_data,
    output thr_state_e        state,
    output logic              pending,
    output logic              blocked,
    output logic [3:0]        status_code,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              launch
);

    logic       accept;
    sync_e      cur_sync;
    logic [3:0] cur_rc;

    assign accept = op_valid && (state == THR_RUN) && !pending;
    assign launch = accept && info.legal && info.uses_bus;

    // Advance the thread state and the status register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= THR_IDLE;
            pending     <= 1'b0;
            blocked     <= 1'b0;
            status_code <= RC_NONE;
            done        <= 1'b0;
            rdata       <= '0;
            cur_sync    <= SYNC_NONE;
            cur_rc      <= RC_NONE;
        end else begin
            done <= 1'b0;
            unique case (state)
                THR_IDLE: begin
                    if (cmd_valid && cmd_code == CMD_RUN) state <= THR_RUN;
                end
                THR_RUN: begin
                    if (accept) begin
                        if (!info.legal) begin
                            status_code <= RC_BAD_OP;
                            done        <= 1'b1;
                        end else if (!info.uses_bus) begin
                            status_code <= info.rc;
                            done        <= 1'b1;
                            if (info.leave) state <= THR_IDLE;
                        end else begin
                            pending     <= 1'b1;
                            status_code <= RC_NONE;
                            cur_sync    <= info.sync;
                            cur_rc      <= info.rc;
                            if (info.sync != SYNC_NONE) state <= THR_WAIT;
                        end
                    end else if (pending && reply) begin
                        pending     <= 1'b0;
                        status_code <= cur_rc;
                        done        <= 1'b1;
                        rdata       <= reply_data;
                    end
                end
                THR_WAIT: begin
                    if (pending && !blocked && reply) begin
                        rdata <= reply_data;
                        if (cur_sync == SYNC_SPIN || reply_data != '0) begin
                            state       <= THR_RUN;
                            pending     <= 1'b0;
                            status_code <= cur_rc;
                            done        <= 1'b1;
                        end else begin
                            blocked <= 1'b1;
                        end
                    end else if (blocked && cmd_valid && cmd_code == CMD_WAKE) begin
                        state       <= THR_RUN;
                        blocked     <= 1'b0;
                        pending     <= 1'b0;
                        status_code <= cur_rc;
                        done        <= 1'b1;
                    end
                end
                default: state <= THR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hw_thread_ctrl.sv
// Hardware thread interface controller top: joins the decoder, the
// address builder, the state machine and the bus sequencer. Assumes a
// single user thread with a fixed thread number.
module hw_thread_ctrl
    import hwt_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                LOCK_W    = 6,
    parameter int                TID_W     = 9,
    parameter logic [TID_W-1:0]  THREAD_ID = 9'h0A3,
    parameter logic [ADDR_W-1:0] SPIN_BASE = 32'h4000_0000,
    parameter logic [ADDR_W-1:0] MTX_BASE  = 32'h4100_0000,
    parameter logic [ADDR_W-1:0] SEM_BASE  = 32'h4200_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_code,
    output logic [3:0]        status_code,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        thread_state,
    output logic [7:0]        dbg_status,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata
);

    op_info_t          info;
    logic [ADDR_W-1:0] l_addr;
    logic [DATA_W-1:0] l_wdata;
    logic              launch;
    logic              reply;
    logic              pending;
    logic              blocked;
    thr_state_e        state;

    hwt_op_decode u_dec (
        .op_code (op_code),
        .info    (info)
    );

    hwt_addr_gen #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_W(LOCK_W), .TID_W(TID_W),
        .THREAD_ID(THREAD_ID), .SPIN_BASE(SPIN_BASE), .MTX_BASE(MTX_BASE),
        .SEM_BASE(SEM_BASE)
    ) u_addr (
        .info     (info),
        .op_addr  (op_addr),
        .op_wdata (op_wdata),
        .addr     (l_addr),
        .wdata    (l_wdata)
    );

    hwt_state_ctrl #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .info        (info),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .reply       (reply),
        .reply_data  (bus_rdata),
        .state       (state),
        .pending     (pending),
        .blocked     (blocked),
        .status_code (status_code),
        .done        (done),
        .rdata       (rdata),
        .launch      (launch)
    );

    hwt_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .l_addr    (l_addr),
        .l_we      (info.bus_write),
        .l_wdata   (l_wdata),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .reply     (reply)
    );

    assign thread_state = state;
    assign dbg_status   = {state, pending, blocked, status_code};

endmodule

// File: rtl/hwt_ctrl_chk.sv
// Assertion checker for the hardware thread interface controller,
// attached to every instance of the top by the bind below.
module hwt_ctrl_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic              cmd_valid,
    input logic [1:0]        cmd_code,
    input logic [3:0]        status_code,
    input logic              done,
    input logic [1:0]        thread_state,
    input logic [7:0]        dbg_status,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack
);

    assert_bus_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_state_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        thread_state != 2'd3);

    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_state == 2'd0) |-> !bus_req);

    assert_run_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_state == 2'd0 && cmd_valid && cmd_code == 2'b01) |=> (thread_state == 2'd1));

    assert_spin_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_state == 2'd1 && !dbg_status[5] && op_valid && op_code == 4'd7)
        |=> (thread_state == 2'd2 && bus_req && !bus_we));

    assert_blocked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_status[4] |-> (!bus_req && thread_state == 2'd2));

    assert_wake_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status[4] && cmd_valid && cmd_code == 2'b10) |=> (thread_state == 2'd1 && done));

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (thread_state == 2'd1 && !dbg_status[5] && op_valid && (op_code == 4'd0 || op_code > 4'd9))
        |=> (!bus_req && status_code == 4'd15 && done && thread_state == 2'd1));

endmodule

bind hw_thread_ctrl hwt_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_valid     (op_valid),
    .op_code      (op_code),
    .cmd_valid    (cmd_valid),
    .cmd_code     (cmd_code),
    .status_code  (status_code),
    .done         (done),
    .thread_state (thread_state),
    .dbg_status   (dbg_status),
    .bus_req      (bus_req),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_ack      (bus_ack)
);

// File: tb/hw_thread_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for the hardware thread interface controller.
module hw_thread_ctrl_tb;

    localparam int          ADDR_W = 32;
    localparam int          DATA_W = 32;
    localparam logic [8:0]  TID    = 9'h0A3;
    localparam logic [31:0] SPIN_B = 32'h4000_0000;
    localparam logic [31:0] MTX_B  = 32'h4100_0000;
    localparam logic [31:0] SEM_B  = 32'h4200_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              op_valid = 1'b0;
    logic [3:0]        op_code = '0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic [DATA_W-1:0] op_wdata = '0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_code = '0;
    logic [3:0]        status_code;
    logic              done;
    logic [DATA_W-1:0] rdata;
    logic [1:0]        thread_state;
    logic [7:0]        dbg_status;
    logic              bus_req;
    logic              bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hw_thread_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_W(6), .TID_W(9), .THREAD_ID(TID),
        .SPIN_BASE(SPIN_B), .MTX_BASE(MTX_B), .SEM_BASE(SEM_B)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_wdata(op_wdata), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .status_code(status_code), .done(done),
        .rdata(rdata), .thread_state(thread_state), .dbg_status(dbg_status),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    function automatic logic [31:0] lock_addr(logic [31:0] base, bit rel, logic [5:0] lk);
        return {base[31:17], 1'b0, rel, lk, TID};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one operation for a single cycle; returns after the edge.
    task automatic issue_op(logic [3:0] code, logic [31:0] addr, logic [31:0] wd);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; op_addr = addr; op_wdata = wd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic send_cmd(logic [1:0] code);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Acknowledge the outstanding request with a reply word.
    task automatic bus_reply(logic [31:0] word);
        int n = 0;
        while (!bus_req && n < 50) begin @(negedge clk); n++; end
        bus_ack = 1'b1; bus_rdata = word;
        @(negedge clk);
        bus_ack = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 state", thread_state, 0);
        check("R1 req", bus_req, 0);
        check("R1 code", status_code, 0);
        check("R1 done", done, 0);
        check("R12 dbg reset", dbg_status, 8'h00);
    endtask

    task automatic t_idle_ignore;
        issue_op(4'd1, 32'h10, 0);
        check("R3 idle op no bus", bus_req, 0);
        check("R3 idle op state", thread_state, 0);
        send_cmd(2'b10);
        check("R2 wake in idle", thread_state, 0);
    endtask

    task automatic t_start;
        send_cmd(2'b01);
        check("R2 run", thread_state, 1);
        send_cmd(2'b01);
        check("R2 run again", thread_state, 1);
        check("R2 no done", done, 0);
    endtask

    task automatic t_read;
        issue_op(4'd1, 32'h0000_1234, 0);
        check("R4 read req", bus_req, 1);
        check("R4 read dir", bus_we, 0);
        check("R4 read addr", bus_addr, 32'h1234);
        check("R12 pending bit", dbg_status, 8'h60);
        issue_op(4'd3, 32'h5, 0);
        @(negedge clk);
        check("R13 req held", bus_req, 1);
        check("R3 R13 addr stable", bus_addr, 32'h1234);
        bus_reply(32'hCAFE);
        check("R4 read code", status_code, 1);
        check("R11 done", done, 1);
        check("R4 rdata", rdata, 32'hCAFE);
        check("R4 state", thread_state, 1);
        check("R3 no second req", bus_req, 0);
        @(negedge clk);
        check("R11 done one cycle", done, 0);
    endtask

    task automatic t_write;
        issue_op(4'd2, 32'h80, 32'h55);
        check("R11 code cleared", status_code, 0);
        check("R4 write dir", bus_we, 1);
        check("R4 write data", bus_wdata, 32'h55);
        check("R4 write addr", bus_addr, 32'h80);
        bus_reply(0);
        check("R4 write code", status_code, 2);
    endtask

    task automatic t_release;
        issue_op(4'd3, 32'h5, 32'hFFFF);
        check("R5 post dir", bus_we, 1);
        check("R5 post addr", bus_addr, lock_addr(SEM_B, 1'b1, 6'd5));
        check("R5 post data", bus_wdata, 32'(TID));
        check("R5 post state", thread_state, 1);
        bus_reply(0);
        check("R5 post code", status_code, 3);
        issue_op(4'd8, 32'h3F, 0);
        check("R5 spin unlock addr", bus_addr, lock_addr(SPIN_B, 1'b1, 6'd63));
        bus_reply(0);
        check("R5 spin unlock code", status_code, 8);
        issue_op(4'd6, 32'h11, 0);
        check("R5 mutex unlock addr", bus_addr, lock_addr(MTX_B, 1'b1, 6'd17));
        bus_reply(0);
        check("R5 mutex unlock code", status_code, 6);
    endtask

    task automatic t_spin;
        issue_op(4'd7, 32'h2, 0);
        check("R6 spin waiting", thread_state, 2);
        check("R6 spin read", bus_we, 0);
        check("R6 spin addr", bus_addr, lock_addr(SPIN_B, 1'b0, 6'd2));
        send_cmd(2'b10);
        check("R8 wake during bus", thread_state, 2);
        check("R8 wake no done", done, 0);
        bus_reply(32'h17);
        check("R6 spin back to run", thread_state, 1);
        check("R6 spin code", status_code, 7);
        check("R6 spin owner word", rdata, 32'h17);
    endtask

    task automatic t_block_grant;
        issue_op(4'd5, 32'h4, 0);
        check("R7 mutex waiting", thread_state, 2);
        check("R7 mutex addr", bus_addr, lock_addr(MTX_B, 1'b0, 6'd4));
        bus_reply(32'h1);
        check("R7 granted run", thread_state, 1);
        check("R7 granted code", status_code, 5);
    endtask

    task automatic t_block_sleep;
        issue_op(4'd4, 32'h9, 0);
        check("R7 sem addr", bus_addr, lock_addr(SEM_B, 1'b0, 6'd9));
        bus_reply(32'h0);
        check("R7 queued waits", thread_state, 2);
        check("R7 queued no done", done, 0);
        check("R12 blocked dbg", dbg_status, 8'hB0);
        repeat (4) @(negedge clk);
        check("R7 bus quiet", bus_req, 0);
        check("R7 still waiting", thread_state, 2);
        send_cmd(2'b10);
        check("R7 woken", thread_state, 1);
        check("R7 woken code", status_code, 4);
        check("R11 woken done", done, 1);
    endtask

    task automatic t_wake_running;
        send_cmd(2'b10);
        check("R8 wake in run", thread_state, 1);
        check("R8 wake in run done", done, 0);
    endtask

    task automatic t_bad;
        issue_op(4'd12, 0, 0);
        check("R10 bad code", status_code, 15);
        check("R10 bad no bus", bus_req, 0);
        check("R10 bad state", thread_state, 1);
        issue_op(4'd0, 0, 0);
        check("R10 nop code", status_code, 15);
    endtask

    task automatic t_exit;
        issue_op(4'd9, 0, 0);
        check("R9 exit idle", thread_state, 0);
        check("R9 exit code", status_code, 9);
        check("R9 exit no bus", bus_req, 0);
        send_cmd(2'b01);
        check("R2 restart", thread_state, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_start();
        t_read();
        t_write();
        t_release();
        t_spin();
        t_block_grant();
        t_block_sleep();
        t_wake_running();
        t_bad();
        t_exit();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule